// File: doc/BRIEF.md
# I2C Slave Byte Engine

This block is the target side of a two-wire serial bus. It watches the clock and data lines for start and stop conditions and compares the first byte of each transfer with a 7-bit address set by the host. On a match it acknowledges the address and then moves whole bytes between the bus and a single host-side byte buffer. It drives the lines only by pulling them low. The two outputs are enables for open-drain pull-downs, and the inputs carry the resolved line levels.

The host sees one buffer register and a few flags. A buffer-full flag shows that the buffer holds a byte that has not been taken. A sticky overflow flag records a byte that arrived while the buffer was still full. A sticky interrupt flag is raised for every byte moved and, when a mode input is set, also for every start and stop. In a read transfer the engine holds the clock low after acknowledging its address, and again after each byte the master acknowledges. The hold ends only when the host has loaded the next byte and then asked for the clock to be released. A busy output tells whether the bus is between a start and a stop.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset the busy output, buffer-full, overflow, interrupt and both pull-down enables are 0. A start (SDA falling while SCL is high) sets busy. A stop (SDA rising while SCL is high) clears it.
- R2: The first byte after a start is taken MSB first. If its upper seven bits equal `own_addr` and both buffer-full and overflow are clear, the engine pulls SDA low for the 9th clock, stores the whole byte in the buffer and sets buffer-full and the interrupt flag. If the address differs, the engine does not acknowledge, leaves all flags unchanged and ignores the bus until the next start.
- R3: Bit 0 of a matched address byte is latched on `xfer_read`: 1 means the master reads and 0 means it writes.
- R4: In a write transfer each data byte is received MSB first, acknowledged, stored in the buffer, and sets buffer-full and the interrupt flag.
- R5: A byte that completes while buffer-full or overflow is set is not acknowledged and leaves the buffer unchanged. If buffer-full was set, overflow becomes 1. The engine then ignores the bus until the next start.
- R6: A `buf_rd` pulse clears buffer-full. The interrupt flag stays set until `irq_clr`, and overflow stays set until `ovf_clr`.
- R7: After it acknowledges an address with bit 0 = 1, the engine holds SCL low once the acknowledge clock ends.
- R8: While SCL is held, a `rel_set` pulse has no effect unless `buf_wr` has loaded the buffer since the hold began. After such a write, `rel_set` frees SCL and the buffer byte is sent MSB first.
- R9: When a byte moves into the transmit shifter, buffer-full clears. When a transmitted byte ends, the interrupt flag is set, and if the master acknowledged it SCL is held low again.
- R10: If the master does not acknowledge a transmitted byte, the engine frees SDA and SCL and ignores further clocks until the next start.
- R11: With `ss_irq_en` = 1, every start and every stop sets the interrupt flag. With `ss_irq_en` = 0 they do not.
- R12: `sda_drive_low` only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_drive_low | output | 1 | Enable for the SCL pull-down (clock hold) |
| sda_drive_low | output | 1 | Enable for the SDA pull-down |
| own_addr | input | 7 | Address this target answers to |
| ss_irq_en | input | 1 | Start and stop also raise the interrupt flag |
| buf_wdata | input | 8 | Byte the host loads for transmission |
| buf_wr | input | 1 | Host write strobe for the buffer |
| buf_rd | input | 1 | Host read strobe that clears buffer-full |
| rel_set | input | 1 | Host request to release a held SCL |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| buf_rdata | output | 8 | Buffer contents |
| buf_full | output | 1 | Buffer holds an untaken byte |
| overflow | output | 1 | Sticky overflow flag |
| irq | output | 1 | Sticky interrupt flag |
| xfer_read | output | 1 | Direction of the current transfer (1 = read) |
| bus_busy | output | 1 | Bus is between a start and a stop |

## Verification
The bench leaves an acknowledged byte unread and then sends another. A design that drops the full-buffer guard would acknowledge that byte and overwrite it, and one that forgets the overflow would leave the flag clear. The bench also asks for a clock release before any byte has been loaded. A design that honours this early release would send stale data, and the bench would see SCL freed too soon. The read transfer ends with a master NACK followed by extra clocks. An engine that keeps driving at that point would show up as non-FF data or as a renewed clock hold. A wrong address and both settings of the start/stop interrupt mode are checked as well, because a faulty match or a faulty mode decode would raise the interrupt flag when it should stay clear.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C slave byte engine.
// Assumes: one engine state register of the enum below.
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // ignore bus until start
        ST_ADDR,   // shifting address byte
        ST_RX,     // shifting write data byte
        ST_ACK,    // driving our acknowledge
        ST_HOLD,   // stretching SCL for host
        ST_TX,     // shifting read data byte out
        ST_TXACK   // sampling master acknowledge
    } eng_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Synchronises SCL and SDA into the clock domain and derives edge
// and start/stop pulses. Assumes SYNC_STAGES >= 2 and an idle-high bus.
module i2cs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // index 0 = SCL, 1 = SDA

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] cur_lines;
    logic [LINES-1:0] prev_lines;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Purpose: metastability chain for one line.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw_lines[g]};
        end
        assign cur_lines[g] = chain[SYNC_STAGES-1];
    end

    // Purpose: one-cycle history of the synchronised lines.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lines <= '1;
        else        prev_lines <= cur_lines;
    end

    assign sda_lvl   = cur_lines[1];
    assign scl_rise  = cur_lines[0] & ~prev_lines[0];
    assign scl_fall  = ~cur_lines[0] & prev_lines[0];
    assign start_det = cur_lines[0] & prev_lines[0] & prev_lines[1] & ~cur_lines[1];
    assign stop_det  = cur_lines[0] & prev_lines[0] & ~prev_lines[1] & cur_lines[1];
endmodule

// File: rtl/i2cs_protocol.sv
// Bit-level engine: address match, byte shifting, acknowledge and
// clock hold. Assumes BYTE_W == ADDR_W + 1 and edge pulses from the
// line synchroniser; emits one-cycle event pulses to the host registers.
module i2cs_protocol
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              buf_full,
    input  logic              overflow,
    input  logic [BYTE_W-1:0] buf_q,
    input  logic              rel_ok,
    output logic              sda_low,
    output logic              scl_low,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ovf_set,
    output logic              tx_take,
    output logic              byte_done,
    output logic              hold_enter,
    output logic              dir_rd
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    eng_state_t        state;
    logic [BYTE_W-1:0] sreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_in;
    logic              addr_hit;

    assign addr_hit = (sreg[BYTE_W-1:1] == own_addr);

    // Purpose: protocol state, shifter and line drive.
    always_ff @(posedge clk) begin
        rx_load    <= 1'b0;
        ovf_set    <= 1'b0;
        tx_take    <= 1'b0;
        byte_done  <= 1'b0;
        hold_enter <= 1'b0;
        if (!rst_n) begin
            state   <= ST_IDLE;
            sreg    <= '0;
            bitcnt  <= '0;
            ack_in  <= 1'b0;
            sda_low <= 1'b0;
            scl_low <= 1'b0;
            rx_byte <= '0;
            dir_rd  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
            scl_low <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
            scl_low <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && bitcnt != LAST) begin
                        sreg   <= {sreg[BYTE_W-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (scl_fall && bitcnt == LAST) begin
                        if (state == ST_ADDR && !addr_hit) begin
                            state <= ST_IDLE;
                        end else if (buf_full || overflow) begin
                            ovf_set <= buf_full;
                            state   <= ST_IDLE;
                        end else begin
                            sda_low <= 1'b1;
                            rx_load <= 1'b1;
                            rx_byte <= sreg;
                            if (state == ST_ADDR) dir_rd <= sreg[0];
                            state   <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        sda_low <= 1'b0;
                        bitcnt  <= '0;
                        if (dir_rd) begin
                            scl_low    <= 1'b1;
                            hold_enter <= 1'b1;
                            state      <= ST_HOLD;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rel_ok) begin
                        scl_low <= 1'b0;
                        sreg    <= buf_q;
                        sda_low <= ~buf_q[BYTE_W-1];
                        tx_take <= 1'b1;
                        bitcnt  <= '0;
                        state   <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt == LAST) begin
                            sda_low <= 1'b0;
                            state   <= ST_TXACK;
                        end else begin
                            sreg    <= {sreg[BYTE_W-2:0], 1'b0};
                            sda_low <= ~sreg[BYTE_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) ack_in <= ~sda_lvl;
                    if (scl_fall) begin
                        byte_done <= 1'b1;
                        if (ack_in) begin
                            scl_low    <= 1'b1;
                            hold_enter <= 1'b1;
                            state      <= ST_HOLD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2cs_host_regs.sv
// Host-facing buffer and flags: buffer, full, overflow, interrupt,
// release request and bus-busy. Assumes single-cycle event pulses
// from the protocol engine and single-cycle host strobes.
module i2cs_host_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              rel_set,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    input  logic              ss_irq_en,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ovf_set,
    input  logic              tx_take,
    input  logic              byte_done,
    input  logic              hold_enter,
    output logic [BYTE_W-1:0] buf_q,
    output logic              buf_full,
    output logic              overflow,
    output logic              irq,
    output logic              rel_ok,
    output logic              bus_busy
);
    logic wr_seen;

    // Purpose: buffer contents and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
        end else begin
            if (rx_load)     buf_q <= rx_byte;
            else if (buf_wr) buf_q <= buf_wdata;
            if (rx_load || buf_wr)       buf_full <= 1'b1;
            else if (tx_take || buf_rd)  buf_full <= 1'b0;
        end
    end

    // Purpose: sticky overflow and interrupt flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (ovf_set)      overflow <= 1'b1;
            else if (ovf_clr) overflow <= 1'b0;
            if (rx_load || byte_done || (ss_irq_en && (start_det || stop_det)))
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

    // Purpose: release request, honoured only after a write during the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
            rel_ok  <= 1'b0;
        end else if (hold_enter || tx_take) begin
            wr_seen <= 1'b0;
            rel_ok  <= 1'b0;
        end else begin
            if (buf_wr)             wr_seen <= 1'b1;
            if (rel_set && wr_seen) rel_ok  <= 1'b1;
        end
    end

    // Purpose: bus-busy tracking between start and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_det) bus_busy <= 1'b1;
        else if (stop_det)  bus_busy <= 1'b0;
    end
endmodule

// File: rtl/i2c_slave_engine.sv
// Top of the I2C slave byte engine: 7-bit addressed target with a
// single host buffer and clock hold on reads. Assumes scl_in/sda_in are
// the resolved open-drain line levels, asynchronous to clk.
module i2c_slave_engine #(
    parameter int ADDR_W      = 7,
    parameter int BYTE_W      = ADDR_W + 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ss_irq_en,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_wr,
    input  logic              buf_rd,
    input  logic              rel_set,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_full,
    output logic              overflow,
    output logic              irq,
    output logic              xfer_read,
    output logic              bus_busy
);
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              rx_load, ovf_set, tx_take, byte_done, hold_enter, rel_ok;
    logic [BYTE_W-1:0] rx_byte;

    i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_protocol #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_proto (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .buf_full(buf_full), .overflow(overflow),
        .buf_q(buf_rdata), .rel_ok(rel_ok), .sda_low(sda_drive_low),
        .scl_low(scl_drive_low), .rx_load(rx_load), .rx_byte(rx_byte),
        .ovf_set(ovf_set), .tx_take(tx_take), .byte_done(byte_done),
        .hold_enter(hold_enter), .dir_rd(xfer_read)
    );

    i2cs_host_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .rel_set(rel_set), .irq_clr(irq_clr),
        .ovf_clr(ovf_clr), .ss_irq_en(ss_irq_en), .start_det(start_det),
        .stop_det(stop_det), .rx_load(rx_load), .rx_byte(rx_byte),
        .ovf_set(ovf_set), .tx_take(tx_take), .byte_done(byte_done),
        .hold_enter(hold_enter), .buf_q(buf_rdata), .buf_full(buf_full),
        .overflow(overflow), .irq(irq), .rel_ok(rel_ok), .bus_busy(bus_busy)
    );
endmodule

// File: rtl/i2cs_checker.sv
// Protocol checker bound to the engine top. Assumes it sees the top's
// ports plus the start/stop and receive-load pulses inside it.
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic buf_full,
    input logic buf_rd,
    input logic buf_wr,
    input logic rx_load,
    input logic start_det,
    input logic stop_det,
    input logic bus_busy,
    input logic overflow,
    input logic ovf_clr,
    input logic irq,
    input logic irq_clr
);
    a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    a_r1_free_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);
    a_r12_sda_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_in);
    a_r8_release_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> $past(buf_full));
    a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !buf_wr && !rx_load) |=> !buf_full);
    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind i2c_slave_engine i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .buf_full(buf_full), .buf_rd(buf_rd),
    .buf_wr(buf_wr), .rx_load(rx_load), .start_det(start_det),
    .stop_det(stop_det), .bus_busy(bus_busy), .overflow(overflow),
    .ovf_clr(ovf_clr), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/i2c_slave_engine_test.sv
// Scoreboard bench: a master model drives the bus, received bytes are
// queued as expectations and compared when the buffer fills.
module i2c_slave_engine_test;
    localparam int Q = 10;
    localparam logic [6:0] ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line;
    logic scl_drive_low, sda_drive_low;
    logic ss_irq_en = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic buf_wr = 0, buf_rd = 0, rel_set = 0, irq_clr = 0, ovf_clr = 0;
    logic [7:0] buf_rdata;
    logic buf_full, overflow, irq, xfer_read, bus_busy;

    int compared = 0, mismatched = 0, r12_viol = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_slave_engine uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(ADDR), .ss_irq_en(ss_irq_en), .buf_wdata(buf_wdata),
        .buf_wr(buf_wr), .buf_rd(buf_rd), .rel_set(rel_set),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .buf_rdata(buf_rdata),
        .buf_full(buf_full), .overflow(overflow), .irq(irq),
        .xfer_read(xfer_read), .bus_busy(bus_busy)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (!scl_line) cyc(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(Q);
        scl_up();     cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(Q);
        scl_up();     cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic put_bit(logic b);
        sda_m = b; cyc(Q);
        scl_up();  cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; cyc(Q);
        scl_up(); cyc(Q / 2);
        b = sda_line; cyc(Q / 2);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic send_byte(logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(logic ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~ack);
    endtask

    task automatic strobe_rd();  buf_rd = 1;  cyc(1); buf_rd = 0;  cyc(2); endtask
    task automatic strobe_iclr(); irq_clr = 1; cyc(1); irq_clr = 0; cyc(2); endtask
    task automatic strobe_oclr(); ovf_clr = 1; cyc(1); ovf_clr = 0; cyc(2); endtask
    task automatic strobe_rel(); rel_set = 1; cyc(1); rel_set = 0; cyc(3); endtask
    task automatic strobe_wr(logic [7:0] d);
        buf_wdata = d; buf_wr = 1; cyc(1); buf_wr = 0; cyc(2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Monitor: compare each receive-driven buffer fill against the queue (R4, R2).
    initial begin
        logic bf_prev = 0, wr_prev = 0, scl_prev = 1, sdl_prev = 0;
        forever begin
            @(negedge clk);
            if (rst_n && buf_full && !bf_prev && !wr_prev) begin
                if (exp_q.size() == 0) chk("R4 unexpected buffer load", 1, 0);
                else chk("R4 scoreboard byte", buf_rdata, exp_q.pop_front());
            end
            if (rst_n && sda_drive_low && !sdl_prev && scl_line && scl_prev) r12_viol++;
            bf_prev = buf_full; wr_prev = buf_wr;
            scl_prev = scl_line; sdl_prev = sda_drive_low;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        #1;
        compared++; mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic a;
        logic [7:0] d;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 reset busy", bus_busy, 0);
        chk("R1 reset full", buf_full, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset overflow", overflow, 0);
        chk("R1 reset pulldowns", {scl_drive_low, sda_drive_low}, 0);

        // Write transfer, start/stop interrupts off.
        bus_start();
        chk("R1 busy after start", bus_busy, 1);
        chk("R11 no irq on start when off", irq, 0);
        exp_q.push_back({ADDR, 1'b0});
        send_byte({ADDR, 1'b0}, a);
        chk("R2 address acked", a, 1);
        chk("R2 irq on address", irq, 1);
        chk("R3 write direction", xfer_read, 0);
        strobe_rd();
        chk("R6 read clears full", buf_full, 0);
        chk("R6 irq kept after read", irq, 1);
        strobe_iclr();
        chk("R6 irq cleared", irq, 0);
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, a);
        chk("R4 data acked", a, 1);
        chk("R4 full set", buf_full, 1);
        send_byte(8'h99, a);
        chk("R5 nack when full", a, 0);
        chk("R5 overflow set", overflow, 1);
        chk("R5 buffer kept", buf_rdata, 8'h3C);
        send_byte(8'h11, a);
        chk("R5 ignored until start", a, 0);
        bus_stop();
        chk("R1 idle after stop", bus_busy, 0);
        strobe_rd();
        chk("R6 overflow kept after read", overflow, 1);
        strobe_oclr();
        chk("R6 overflow cleared", overflow, 0);
        strobe_iclr();

        // Wrong address.
        bus_start();
        send_byte({7'h33, 1'b0}, a);
        chk("R2 mismatch nack", a, 0);
        chk("R2 mismatch no load", buf_full, 0);
        chk("R2 mismatch no irq", irq, 0);
        bus_stop();

        // Read transfer, start/stop interrupts on.
        ss_irq_en = 1'b1;
        bus_start();
        chk("R11 irq on start", irq, 1);
        strobe_iclr();
        exp_q.push_back({ADDR, 1'b1});
        send_byte({ADDR, 1'b1}, a);
        chk("R2 read address acked", a, 1);
        chk("R3 read direction", xfer_read, 1);
        chk("R7 clock held", scl_drive_low, 1);
        strobe_rd();
        strobe_rel();
        chk("R8 early release ignored", scl_drive_low, 1);
        strobe_wr(8'hA7);
        chk("R8 still held after write", scl_drive_low, 1);
        strobe_rel();
        chk("R8 clock freed", scl_drive_low, 0);
        chk("R9 full cleared on take", buf_full, 0);
        strobe_iclr();
        recv_byte(1'b1, d);
        chk("R8 first byte out", d, 8'hA7);
        chk("R9 irq per byte", irq, 1);
        chk("R9 held again after ack", scl_drive_low, 1);
        strobe_iclr();
        strobe_wr(8'h4E);
        strobe_rel();
        recv_byte(1'b0, d);
        chk("R8 second byte out", d, 8'h4E);
        chk("R10 clock free after nack", scl_drive_low, 0);
        chk("R10 data free after nack", sda_drive_low, 0);
        recv_byte(1'b0, d);
        chk("R10 bus ignored after nack", d, 8'hFF);
        chk("R10 no hold after nack", scl_drive_low, 0);
        strobe_iclr();
        bus_stop();
        chk("R11 irq on stop", irq, 1);
        chk("R1 idle after read", bus_busy, 0);

        chk("R4 queue drained", exp_q.size(), 0);
        chk("R12 sda pulled only with scl low", r12_viol, 0);
        summary();
    end
endmodule